// File: doc/BRIEF.md
# Mixed-Latency Execute Stage

This block is one execute slot of an in-order pipeline. An operation can take one of two paths. A single-cycle path is combinational and produces its result in the same cycle. A three-step pipelined path returns its result two cycles after the request.

A one-bit wait state lets the slot use both paths. When an operation is sent down the long path, the slot enters the wait state. It keeps that operation at its input and offers nothing downstream until the long path has a response. It then passes the response out, accepts the input operation and leaves the wait state. Arithmetic on both paths is a fixed placeholder transform.

Both data interfaces are valid/ready.
- On the input side, upstream must hold `op_valid`, `op_long` and `op_data` steady until a cycle with `op_valid && op_ready`.
- On the output side, the block holds `res_valid` and `res_data` steady until a cycle with `res_valid && res_ready`.
- Back-pressure passes straight through. With `res_ready` low, no operation completes and no input is accepted.

Top module: `exec_stage`

## Requirements
- R1: With the wait state clear and `op_valid`=1, `op_long`=1, the block sends a request to the long path in that cycle and enters the wait state at the next edge. In the issue cycle, `res_valid`=0 and `op_ready`=0.
- R2: With the wait state clear and `op_valid`=1, `op_long`=0, the same cycle shows `res_valid`=1 and `res_data` = `op_data`+1 (mod 2^W). `op_ready` equals `res_ready` in that cycle.
- R3: A long operation issued in cycle t shows `res_valid`=1 from cycle t+2 on. In the first such cycle with `res_ready`=1, the input is accepted (`op_ready`=1) and the wait state clears at that edge.
- R4: The long-path result is the input x after three steps: s1 = x + 2x, then s2 = s1 rotated left by ROT bits, then the result = s2 XOR a mask of alternating bits with bit 0 set (0x5555 for W=16, ROT=4).
- R5: `op_ready` is 1 only in a cycle where `res_valid` and `res_ready` are both 1. With the wait state clear and `op_valid`=0, `res_valid`=0.
- R6: While in the wait state, `op_ready` stays 0 until the response is taken, so later operations are blocked.
- R7: While `res_valid`=1 and `res_ready`=0, the next cycle still shows `res_valid`=1 with unchanged `res_data`.
- R8: After reset, the wait state is clear and `res_valid`=0 and `op_ready`=0 while `op_valid`=0.
- R9: At most one long-path operation is outstanding. A new request is never issued while in the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Input operation present |
| op_ready | output | 1 | Input operation accepted this cycle |
| op_long | input | 1 | 1 selects the three-step path, 0 the single-cycle path |
| op_data | input | W | Operand |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | W | Result |

## Verification
A wait state that is set wrongly shows up at the ports in the next cycle. A stuck wait state freezes `op_ready` at 0 and a later single-cycle operation produces no result. A wait state that is missing lets a single-cycle result or an early `op_ready` appear in the cycle after an issue. Damage in the long path's buffers shows up two cycles after issue, either as the wrong `res_data` or as `res_valid` arriving in the wrong cycle. The reference model compares `op_ready`, `res_valid` and the valid `res_data` on every clock, so each of these faults is reported within a cycle or two.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_WAIT = 1'b1
  } slot_state_e;
endpackage

// File: rtl/short_path.sv
module short_path #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  assign y = a + W'(1);
endmodule

// File: rtl/long_path.sv
module long_path #(
  parameter int W   = 16,
  parameter int ROT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  localparam logic [W-1:0] MASK = W'({W{2'b01}});

  logic [W-1:0] step1, step2;
  logic [W-1:0] b1_q, b2_q;
  logic         b1_v, b2_v;
  logic         b2_free, move12;

  // first step on request
  assign step1 = req_data + (req_data << 1);

  // middle step between the two buffers
  generate
    if (ROT == 0) begin : g_norot
      assign step2 = b1_q;
    end else begin : g_rot
      assign step2 = {b1_q[W-1-ROT:0], b1_q[W-1:W-ROT]};
    end
  endgenerate

  assign b2_free   = !b2_v || rsp_ready;
  assign move12    = b1_v && b2_free;
  assign req_ready = !b1_v || move12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_v <= 1'b0;
      b1_q <= '0;
      b2_v <= 1'b0;
      b2_q <= '0;
    end else begin
      if (req_valid && req_ready) begin
        b1_v <= 1'b1;
        b1_q <= step1;
      end else if (move12) begin
        b1_v <= 1'b0;
      end
      if (move12) begin
        b2_v <= 1'b1;
        b2_q <= step2;
      end else if (rsp_ready) begin
        b2_v <= 1'b0;
      end
    end
  end

  // last step on response dequeue
  assign rsp_valid = b2_v;
  assign rsp_data  = b2_q ^ MASK;
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_long,
  output logic         op_ready,
  input  logic [W-1:0] short_res,
  output logic         req_valid,
  input  logic         req_ready,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [W-1:0] rsp_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         waiting
);
  import exec_pkg::*;

  slot_state_e state_q, state_d;

  always_comb begin
    op_ready  = 1'b0;
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    res_valid = 1'b0;
    res_data  = short_res;
    state_d   = state_q;
    if (state_q == SLOT_IDLE) begin
      if (op_valid) begin
        if (op_long) begin
          req_valid = 1'b1;
          if (req_ready) state_d = SLOT_WAIT;
        end else begin
          res_valid = 1'b1;
          op_ready  = res_ready;
        end
      end
    end else begin
      res_valid = rsp_valid;
      res_data  = rsp_data;
      rsp_ready = res_ready;
      op_ready  = rsp_valid && res_ready;
      if (rsp_valid && res_ready) state_d = SLOT_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_IDLE;
    else        state_q <= state_d;
  end

  assign waiting = (state_q == SLOT_WAIT);
endmodule

// File: rtl/exec_stage.sv
module exec_stage #(
  parameter int W   = 16,
  parameter int ROT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic         op_long,
  input  logic [W-1:0] op_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data
);
  logic [W-1:0] short_res, rsp_data;
  logic         req_valid, req_ready, rsp_valid, rsp_ready, waiting;
  logic         req_fire;

  assign req_fire = req_valid && req_ready;

  short_path #(.W(W)) u_short (.a(op_data), .y(short_res));

  long_path #(.W(W), .ROT(ROT)) u_long (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(op_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  slot_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_long(op_long), .op_ready(op_ready),
    .short_res(short_res),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .waiting(waiting)
  );
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic         op_long,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_data,
  input logic         waiting,
  input logic         req_fire
);
  p_issue_sets_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> waiting);

  p_issue_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && op_valid && op_long) |-> (!res_valid && !op_ready));

  p_short_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && op_valid && !op_long) |-> (res_valid && (op_ready == res_ready)));

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && res_valid && res_ready) |=> !waiting);

  p_accept_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (res_valid && res_ready));

  p_wait_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !res_valid) |-> !op_ready);

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> !waiting);
endmodule

bind exec_stage exec_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_long(op_long), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .waiting(waiting), .req_fire(req_fire)
);

// File: tb/tb_exec_stage.sv
module tb_exec_stage;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0, op_long = 1'b0, res_ready = 1'b0;
  logic [W-1:0] op_data = '0;
  logic         op_ready, res_valid;
  logic [W-1:0] res_data;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference model state
  bit           m_wait = 0;
  int           m_cnt = 0;
  logic [W-1:0] m_res = '0;
  bit           prev_stall = 0;
  logic [W-1:0] prev_data = '0;

  always #2.5 clk = ~clk;

  exec_stage #(.W(W), .ROT(4)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_long(op_long), .op_data(op_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [W-1:0] long_ref(logic [W-1:0] x);
    logic [W-1:0] s1, s2;
    s1 = x * 3;
    s2 = (s1 << 4) | (s1 >> (W - 4));
    return s2 ^ 16'h5555;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive is already applied at negedge; compare, then advance model
  task automatic step();
    bit ev, er;
    logic [W-1:0] ed;
    string tg;
    #1;
    ev = 0; er = 0; ed = '0;
    if (!m_wait) begin
      if (op_valid && op_long) begin ev = 0; er = 0; tg = "R1"; end
      else if (op_valid) begin ev = 1; er = res_ready; ed = op_data + 1'b1; tg = "R2"; end
      else tg = "R5";
    end else begin
      ev = (m_cnt >= 2); er = ev && res_ready; ed = m_res;
      tg = ev ? "R3" : "R6";
    end
    chk({tg, " res_valid"}, W'(res_valid), W'(ev));
    chk({tg, " op_ready"}, W'(op_ready), W'(er));  // R5 R9 via blocking
    if (ev) chk(m_wait ? "R4 res_data" : "R2 res_data", res_data, ed);
    if (prev_stall && ev) chk("R7 held data", res_data, prev_data);
    prev_stall = ev && !res_ready;
    prev_data  = res_data;
    @(posedge clk);
    if (!m_wait && op_valid && op_long) begin
      m_wait = 1; m_cnt = 1; m_res = long_ref(op_data);
    end else if (m_wait) begin
      if (ev && res_ready) m_wait = 0;
      m_cnt++;
    end
    if (op_valid && er) op_valid <= 1'b0;
    @(negedge clk);
  endtask

  task automatic present(bit lng, logic [W-1:0] d);
    op_valid = 1'b1; op_long = lng; op_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 res_valid in reset", W'(res_valid), '0);
    chk("R8 op_ready in reset", W'(op_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    step();
    // R2 short op, downstream ready
    res_ready = 1; present(0, 16'h00ff); step();
    // R2 wrap-around
    present(0, 16'hffff); step();
    // R1/R3/R4 long op with ready
    present(1, 16'h1234); repeat (4) step();
    // R7 long op with back-pressure
    res_ready = 0; present(1, 16'h8001);
    repeat (5) step();
    res_ready = 1; repeat (2) step();
    // R6 long then short back-to-back
    present(1, 16'h0f0f); repeat (3) step();
    present(0, 16'h0042); step();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (!op_valid && ($urandom % 10) < 7)
        present(($urandom % 10) < 4, W'($urandom));
      res_ready = (($urandom % 10) < 7);
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule